// File: doc/BRIEF.md
# Zero-turnaround flow-through synchronous SRAM

This block is a synthesizable model of a pipelined synchronous static memory that needs no idle cycle when the bus changes direction. Command, address and control are captured at one rising clock edge. The matching data phase takes place in the next cycle. Write data is registered at the edge that closes that phase. Read data flows combinationally from the array, addressed by registered state, with no output register. Because every command is delayed by exactly one cycle, a read can follow a write, or a write can follow a read, on consecutive edges.

An internal four-beat burst counter lets one loaded address serve up to four consecutive transfers. The order is either linear or interleaved. A clock enable stalls the whole block. A sleep input gates the internal clock and keeps the array contents. Three chip selects and an asynchronous output enable govern the drive of the read bus. The bus is split into an input, an output and a drive flag, in place of a true three-state pin.

The control is a three-state machine. PH_IDLE means no data phase is pending, PH_READ means a read data phase is pending, and PH_WRITE means a write data phase is pending. On an enabled edge with load low and the chip selected, every state moves to PH_READ on a read command (transition LOAD_RD) or to PH_WRITE on a write command (LOAD_WR). On an enabled edge with load low and the chip not selected, every state moves to PH_IDLE (DESELECT). On an enabled edge with load high, PH_READ and PH_WRITE remain in place and the beat count advances (ADVANCE), while PH_IDLE stays idle (HOLD_IDLE). A stalled or sleeping edge changes nothing (FREEZE).

Top module: `zft_sram`

## Requirements
- R1: A read command (load_n low, chip selected, rd_wr_n high) at edge N sets `rdata_drive` high during the cycle after N, when oe_n is low and sleep is low. In that cycle `rdata` holds the array word at the command's address.
- R2: A write command at edge N stores `wdata`, sampled at the next enabled edge, into the addressed word. Only the bytes whose `byte_we_n` bit, sampled with the command, is 0 are written. Bit i covers data bits [9i+8:9i].
- R3: Commands may alternate between read and write on consecutive edges with no idle cycle. A read issued at the edge right after a write to the same address returns the newly written data.
- R4: An edge with cken_n high leaves the state, the address, the beat count and the array unchanged. Any pending data phase carries over to the next enabled edge.
- R5: The chip is selected only when sel_a_n=0, sel_b_n=0 and sel_c=1. A load edge without that selection starts no operation, and `rdata_drive` is low in the following cycle.
- R6: A data phase pending from the previous command completes at an edge that deselects the chip. A pending write is stored, and a pending read is driven in the cycle before that edge.
- R7: `rdata_drive` is low in the cycle after a write command.
- R8: An enabled edge with load_n high advances the beat count of a pending burst by one, modulo 4. The two low address bits become base+beat when interleave=0, or base XOR beat when interleave=1, while the upper bits stay unchanged. On a burst write, the byte enables are sampled again at each advance.
- R9: oe_n high forces `rdata_drive` low at once and changes no internal state.
- R10: While sleep is high, no state changes, no write happens, the array is kept and `rdata_drive` is low.
- R11: After reset, the block is idle and `rdata_drive` is low.
- R12: An enabled edge with load_n high while idle leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| cken_n | input | 1 | Clock enable, active low |
| sleep | input | 1 | Sleep request, gates the internal clock |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b_n | input | 1 | Chip select, active low |
| sel_c | input | 1 | Chip select, active high |
| load_n | input | 1 | Low loads a new command, high advances the burst |
| rd_wr_n | input | 1 | High for a read command, low for a write command |
| byte_we_n | input | BYTES | Per-byte write enables, active low |
| interleave | input | 1 | Static burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | BYTES*9 | Write data bus |
| rdata | output | BYTES*9 | Flow-through read data |
| rdata_drive | output | 1 | High when the read bus would be driven |

## Verification
On every cycle, the bound assertions check the state-machine transitions. A stall or sleep freezes the phase and the beat count, a write or deselect command leaves the bus undriven afterwards, and a burst advance steps the beat by one. The contents of memory can only be shown by the bench's scenarios. These scenarios cover byte-masked writes, read-after-write across the direction change, linear and interleaved address orders, and a pending transfer that completes under deselect, stall or sleep. The bench follows a reference array through thousands of random cycles.

// File: rtl/zft_pkg.sv
package zft_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;

    localparam int BEATS  = 4;
    localparam int BEAT_W = 2;
endpackage

// File: rtl/zft_ctrl.sv
module zft_ctrl
    import zft_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              load_n,
    input  logic              chip_sel,
    input  logic              rd_wr_n,
    input  logic [BYTES-1:0]  byte_we_n,
    input  logic [ADDR_W-1:0] addr,
    output phase_e            phase_q,
    output logic [ADDR_W-1:0] base_q,
    output logic [BEAT_W-1:0] beat_q,
    output logic [BYTES-1:0]  be_q
);
    phase_e            phase_d;
    logic [ADDR_W-1:0] base_d;
    logic [BEAT_W-1:0] beat_d;
    logic [BYTES-1:0]  be_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            base_q  <= '0;
            beat_q  <= '0;
            be_q    <= '1;
        end else begin
            phase_q <= phase_d;
            base_q  <= base_d;
            beat_q  <= beat_d;
            be_q    <= be_d;
        end
    end

    always_comb begin
        phase_d = phase_q;
        base_d  = base_q;
        beat_d  = beat_q;
        be_d    = be_q;
        if (step_en) begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (!load_n && chip_sel) begin
                        phase_d = rd_wr_n ? PH_READ : PH_WRITE;
                        base_d  = addr;
                        beat_d  = '0;
                        be_d    = byte_we_n;
                    end
                end
                PH_READ, PH_WRITE: begin
                    if (!load_n) begin
                        if (chip_sel) begin
                            phase_d = rd_wr_n ? PH_READ : PH_WRITE;
                            base_d  = addr;
                            beat_d  = '0;
                            be_d    = byte_we_n;
                        end else begin
                            phase_d = PH_IDLE;
                        end
                    end else begin
                        beat_d = beat_q + 1'b1;
                        if (phase_q == PH_WRITE) be_d = byte_we_n;
                    end
                end
                default: phase_d = PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/zft_burst.sv
module zft_burst
    import zft_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [BEAT_W-1:0] beat,
    input  logic              interleave,
    output logic [ADDR_W-1:0] eff_addr
);
    logic [BEAT_W-1:0] low;

    always_comb begin
        if (interleave) low = base[BEAT_W-1:0] ^ beat;
        else            low = base[BEAT_W-1:0] + beat;
    end

    generate
        if (ADDR_W > BEAT_W) begin : g_upper
            assign eff_addr = {base[ADDR_W-1:BEAT_W], low};
        end else begin : g_low_only
            assign eff_addr = low;
        end
    endgenerate
endmodule

// File: rtl/zft_array.sv
module zft_array #(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [BYTES-1:0]        be_n,
    input  logic [BYTES*BYTE_W-1:0] wdata,
    output logic [BYTES*BYTE_W-1:0] rdata
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = BYTES * BYTE_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < BYTES; b++) begin
                if (!be_n[b]) mem[addr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
            end
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/zft_sram.sv
module zft_sram
    import zft_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cken_n,
    input  logic                    sleep,
    input  logic                    sel_a_n,
    input  logic                    sel_b_n,
    input  logic                    sel_c,
    input  logic                    load_n,
    input  logic                    rd_wr_n,
    input  logic [BYTES-1:0]        byte_we_n,
    input  logic                    interleave,
    input  logic                    oe_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [BYTES*BYTE_W-1:0] wdata,
    output logic [BYTES*BYTE_W-1:0] rdata,
    output logic                    rdata_drive
);
    localparam int DATA_W = BYTES * BYTE_W;

    logic              step_en;
    logic              chip_sel;
    logic              wr_en;
    phase_e            phase_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] eff_addr;
    logic [BEAT_W-1:0] beat_q;
    logic [BYTES-1:0]  be_q;
    logic [DATA_W-1:0] arr_rd;

    assign step_en  = !cken_n && !sleep;
    assign chip_sel = !sel_a_n && !sel_b_n && sel_c;

    zft_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .load_n    (load_n),
        .chip_sel  (chip_sel),
        .rd_wr_n   (rd_wr_n),
        .byte_we_n (byte_we_n),
        .addr      (addr),
        .phase_q   (phase_q),
        .base_q    (base_q),
        .beat_q    (beat_q),
        .be_q      (be_q)
    );

    zft_burst #(.ADDR_W(ADDR_W)) u_burst (
        .base       (base_q),
        .beat       (beat_q),
        .interleave (interleave),
        .eff_addr   (eff_addr)
    );

    assign wr_en = step_en && (phase_q == PH_WRITE);

    zft_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_array (
        .clk   (clk),
        .wr_en (wr_en),
        .addr  (eff_addr),
        .be_n  (be_q),
        .wdata (wdata),
        .rdata (arr_rd)
    );

    always_comb begin
        rdata_drive = 1'b0;
        unique case (phase_q)
            PH_READ:  rdata_drive = !oe_n && !sleep;
            PH_IDLE,
            PH_WRITE: rdata_drive = 1'b0;
            default:  rdata_drive = 1'b0;
        endcase
    end

    assign rdata = arr_rd;
endmodule

// File: rtl/zft_checks.sv
module zft_checks
    import zft_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         cken_n,
    input logic         sleep,
    input logic         oe_n,
    input logic         load_n,
    input logic         chip_sel,
    input logic         rd_wr_n,
    input phase_e       phase_q,
    input logic [BEAT_W-1:0] beat_q,
    input logic         rdata_drive
);
    logic en;
    assign en = !cken_n && !sleep;

    assert_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cken_n || sleep) |=> ($stable(phase_q) && $stable(beat_q)));

    assert_read_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load_n && chip_sel && rd_wr_n) |=> (phase_q == PH_READ));

    assert_deselect_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load_n && !chip_sel) |=> (phase_q == PH_IDLE && !rdata_drive));

    assert_write_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load_n && chip_sel && !rd_wr_n) |=> !rdata_drive);

    assert_beat_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && load_n && phase_q != PH_IDLE) |=> (beat_q == BEAT_W'($past(beat_q) + 1'b1)));

    assert_oe_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n || sleep) |-> !rdata_drive);

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (en && load_n && phase_q == PH_IDLE) |=> (phase_q == PH_IDLE));
endmodule

bind zft_sram zft_checks u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .cken_n      (cken_n),
    .sleep       (sleep),
    .oe_n        (oe_n),
    .load_n      (load_n),
    .chip_sel    (chip_sel),
    .rd_wr_n     (rd_wr_n),
    .phase_q     (phase_q),
    .beat_q      (beat_q),
    .rdata_drive (rdata_drive)
);

// File: tb/tb_zft_sram.sv
module tb_zft_sram;
    localparam int ADDR_W = 6;
    localparam int BYTES  = 2;
    localparam int BYTE_W = 9;
    localparam int DATA_W = BYTES * BYTE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cken_n = 1'b0, sleep = 1'b0, oe_n = 1'b0;
    logic              sel_a_n = 1'b1, sel_b_n = 1'b1, sel_c = 1'b0;
    logic              load_n = 1'b1, rd_wr_n = 1'b1, interleave = 1'b0;
    logic [BYTES-1:0]  byte_we_n = '1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              rdata_drive;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    logic [DATA_W-1:0] ref_mem [DEPTH];
    int                ref_ph = 0; // 0 idle, 1 read, 2 write
    logic [ADDR_W-1:0] ref_base = '0;
    logic [1:0]        ref_beat = '0;
    logic [BYTES-1:0]  ref_be = '1;

    always #2 clk = ~clk;

    zft_sram #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) dut (
        .clk(clk), .rst_n(rst_n), .cken_n(cken_n), .sleep(sleep),
        .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
        .load_n(load_n), .rd_wr_n(rd_wr_n), .byte_we_n(byte_we_n),
        .interleave(interleave), .oe_n(oe_n), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rdata_drive(rdata_drive)
    );

    function automatic logic [ADDR_W-1:0] eff(input logic [ADDR_W-1:0] b,
                                              input logic [1:0] bt, input logic il);
        logic [1:0] lo;
        lo = il ? (b[1:0] ^ bt) : (b[1:0] + bt);
        return {b[ADDR_W-1:2], lo};
    endfunction

    function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_w,
                                                input logic [DATA_W-1:0] new_w,
                                                input logic [BYTES-1:0] ben);
        logic [DATA_W-1:0] r;
        r = old_w;
        for (int b = 0; b < BYTES; b++)
            if (!ben[b]) r[b*BYTE_W +: BYTE_W] = new_w[b*BYTE_W +: BYTE_W];
        return r;
    endfunction

    task automatic check(input string tag, input logic got_drv, input logic exp_drv,
                         input logic [DATA_W-1:0] got_d, input logic [DATA_W-1:0] exp_d);
        checks++;
        if (got_drv !== exp_drv || (exp_drv && got_d !== exp_d)) begin
            fails++;
            $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
                     tag, got_drv, got_d, exp_drv, exp_d);
        end
    endtask

    // one cycle: apply inputs, check outputs for the pending phase, advance model
    task automatic step(input string tag, input bit cke_n, input bit sel_ok,
                        input bit ld_n, input bit rw, input logic [BYTES-1:0] ben,
                        input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                        input bit oen, input bit slp);
        logic exp_drv;
        logic [ADDR_W-1:0] ea;
        @(negedge clk);
        cken_n = cke_n; sleep = slp; oe_n = oen; load_n = ld_n; rd_wr_n = rw;
        byte_we_n = ben; addr = a; wdata = wd;
        if (sel_ok) begin
            sel_a_n = 1'b0; sel_b_n = 1'b0; sel_c = 1'b1;
        end else begin
            sel_a_n = 1'b0; sel_b_n = 1'b0; sel_c = 1'b1;
            case ($urandom % 3)
                0: sel_a_n = 1'b1;
                1: sel_b_n = 1'b1;
                default: sel_c = 1'b0;
            endcase
        end
        #1;
        ea = eff(ref_base, ref_beat, interleave);
        exp_drv = (ref_ph == 1) && !oen && !slp;
        check(tag, rdata_drive, exp_drv, rdata, ref_mem[ea]);
        if (!cke_n && !slp) begin
            if (ref_ph == 2) ref_mem[ea] = merge(ref_mem[ea], wd, ref_be);
            if (!ld_n) begin
                if (sel_ok) begin
                    ref_ph = rw ? 1 : 2; ref_base = a; ref_beat = 2'd0; ref_be = ben;
                end else begin
                    ref_ph = 0;
                end
            end else if (ref_ph != 0) begin
                ref_beat = ref_beat + 2'd1;
                if (ref_ph == 2) ref_be = ben;
            end
        end
    endtask

    task automatic nop(input string tag);
        step(tag, 1'b0, 1'b1, 1'b1, 1'b1, '1, '0, '0, 1'b0, 1'b0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        check("R11 reset", rdata_drive, 1'b0, rdata, '0);
        rst_n = 1'b1;
        // R12: advance while idle stays idle
        nop("R12 idle advance");
        nop("R12 idle advance");
        // R3/R2: fill every word with back-to-back writes, full enables
        for (int i = 0; i < DEPTH; i++)
            step("R2 fill", 1'b0, 1'b1, 1'b0, 1'b0, '0, ADDR_W'(i), DATA_W'(i * 97 + 5), 1'b0, 1'b0);
        // R3: read right after write, same address, no idle cycle
        step("R3 wr", 1'b0, 1'b1, 1'b0, 1'b0, '0, 6'd9, 18'h0, 1'b0, 1'b0);
        step("R3 rd", 1'b0, 1'b1, 1'b0, 1'b1, '1, 6'd9, 18'h2ABCD, 1'b0, 1'b0);
        step("R3 wr after rd", 1'b0, 1'b1, 1'b0, 1'b0, 2'b10, 6'd9, 18'h0, 1'b0, 1'b0);
        // R2: only byte 0 written
        step("R2 rd", 1'b0, 1'b1, 1'b0, 1'b1, '1, 6'd9, 18'h3FFFF, 1'b0, 1'b0);
        step("R1 rd", 1'b0, 1'b1, 1'b0, 1'b1, '1, 6'd10, 18'h0, 1'b0, 1'b0);
        // R6: deselect while read pending still drives the read
        step("R6 deselect", 1'b0, 1'b0, 1'b0, 1'b1, '1, 6'd0, 18'h0, 1'b0, 1'b0);
        nop("R5 after deselect");
        // R6: write pending completes under deselect
        step("R6 wr", 1'b0, 1'b1, 1'b0, 1'b0, '0, 6'd20, 18'h0, 1'b0, 1'b0);
        step("R6 deselect wr", 1'b0, 1'b0, 1'b0, 1'b1, '1, 6'd0, 18'h1F00F, 1'b0, 1'b0);
        step("R6 rd", 1'b0, 1'b1, 1'b0, 1'b1, '1, 6'd20, 18'h0, 1'b0, 1'b0);
        // R7: write command then bus quiet
        step("R7 wr", 1'b0, 1'b1, 1'b0, 1'b0, '1, 6'd21, 18'h0, 1'b0, 1'b0);
        step("R7 quiet", 1'b0, 1'b1, 1'b0, 1'b1, '1, 6'd21, 18'h0, 1'b0, 1'b0);
        // R8: linear burst read from base 1, then interleaved from base 2
        interleave = 1'b0;
        step("R8 lin load", 1'b0, 1'b1, 1'b0, 1'b1, '1, 6'd33, 18'h0, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) nop("R8 lin beat");
        interleave = 1'b1;
        step("R8 il load", 1'b0, 1'b1, 1'b0, 1'b1, '1, 6'd46, 18'h0, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) nop("R8 il beat");
        // R8: burst write with per-beat byte enables, then read back
        interleave = 1'b0;
        step("R8 bw load", 1'b0, 1'b1, 1'b0, 1'b0, 2'b01, 6'd50, 18'h0, 1'b0, 1'b0);
        step("R8 bw beat", 1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 6'd0, 18'h15555, 1'b0, 1'b0);
        step("R8 bw beat", 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 6'd0, 18'h0AAAA, 1'b0, 1'b0);
        step("R8 bw beat", 1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 6'd0, 18'h12345, 1'b0, 1'b0);
        step("R8 bw end", 1'b0, 1'b1, 1'b0, 1'b1, '1, 6'd48, 18'h3C3C3, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) nop("R8 bw readback");
        // R4: stall with read pending holds data
        step("R4 rd", 1'b0, 1'b1, 1'b0, 1'b1, '1, 6'd7, 18'h0, 1'b0, 1'b0);
        step("R4 stall", 1'b1, 1'b1, 1'b0, 1'b0, '0, 6'd8, 18'h0, 1'b0, 1'b0);
        step("R4 stall", 1'b1, 1'b0, 1'b0, 1'b1, '0, 6'd8, 18'h0, 1'b0, 1'b0);
        nop("R4 resume");
        // R9: oe_n high hides a pending read, then state still there
        step("R9 rd", 1'b0, 1'b1, 1'b0, 1'b1, '1, 6'd12, 18'h0, 1'b0, 1'b0);
        step("R9 oe off", 1'b1, 1'b1, 1'b1, 1'b1, '1, 6'd0, 18'h0, 1'b1, 1'b0);
        step("R9 oe on", 1'b0, 1'b1, 1'b1, 1'b1, '1, 6'd0, 18'h0, 1'b0, 1'b0);
        // R10: sleep with a write pending defers it
        step("R10 wr", 1'b0, 1'b1, 1'b0, 1'b0, '0, 6'd30, 18'h0, 1'b0, 1'b0);
        step("R10 sleep", 1'b0, 1'b1, 1'b0, 1'b1, '1, 6'd31, 18'h11111, 1'b0, 1'b1);
        step("R10 wake", 1'b0, 1'b1, 1'b0, 1'b1, '1, 6'd30, 18'h22222, 1'b0, 1'b0);
        nop("R10 readback");
        // random mix
        for (int n = 0; n < 4000; n++) begin
            bit ck, sl, oe, ld, sel, rw;
            ck  = ($urandom % 10) == 0;
            sl  = ($urandom % 20) == 0;
            oe  = ($urandom % 10) == 0;
            ld  = ($urandom % 10) < 4;
            sel = ($urandom % 10) != 0;
            rw  = $urandom % 2;
            if (n == 2000) interleave = 1'b1;
            step(ref_ph == 1 ? "R1 random" : "R5 random", ck, sel, ld, rw,
                 BYTES'($urandom), ADDR_W'($urandom), DATA_W'($urandom), oe, sl);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule